// File: doc/BRIEF.md
# Operand Address Generator

This unit turns one memory operand of a small 8-bit controller into a 16-bit data address. It also produces the bit position inside the addressed byte. A two-bit mode input selects one of four ways of forming the address: a banked direct byte with a bit number, a signed byte displacement from an index register, an indirect pointer register, or a slot in the general-purpose register file. The address, the bit position and a strobe come out of registers on the clock edge that follows a request.

For bit set and bit clear instructions, the unit also performs the read-modify-write merge. The controller fetches the byte at the generated address and presents it with a read strobe. One cycle later the unit returns the byte with only the selected bit forced high or low, ready to be written back. Instruction decode, the memory and the flag logic are outside this block.

Top module: `opnd_addr_gen`

## Requirements
- R1: In direct mode (mode = 0), an operand byte of 0x00 to 0x7F gives the address 0x00_00 plus the operand, unchanged.
- R2: In direct mode, an operand byte of 0x80 to 0xFF gives the address 0x0080 + {dbank[2:0], operand[6:0]}. This always lies in 0x0080 to 0x047F.
- R3: In direct mode, the bit position output equals opc[2:0]. In every other mode it is 0.
- R4: In index mode (mode = 1), the address is idx plus the sign-extended operand byte, wrapped modulo 65536.
- R5: In pointer mode (mode = 2), the address is the xptr input as it was at the request.
- R6: In register mode (mode = 3), the address is {8'h01, rbank[4:0], opc[2:0]}.
- R7: addr_vld is high for exactly the one cycle after each cycle in which req is high, and low otherwise. addr and bit_idx hold their values between requests.
- R8: A synchronous reset clears addr, bit_idx, addr_vld, illegal, wr_data and wr_vld to 0.
- R9: illegal is high in the cycle after a request that has bitop = 1 with mode other than 0. It is low after any other request and whenever addr_vld is low.
- R10: With set_bit = 1, the cycle after rd_stb gives wr_data = rd_data with bit bit_idx forced to 1. bit_idx is the value present at the rd_stb cycle.
- R11: With set_bit = 0, the cycle after rd_stb gives wr_data = rd_data with bit bit_idx forced to 0. All other bits are unchanged.
- R12: wr_vld is high for exactly the one cycle after each cycle in which rd_stb is high. wr_data holds between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Address request strobe |
| mode | input | 2 | 0 direct, 1 index, 2 pointer, 3 register |
| opnd | input | 8 | Operand byte (direct address or signed offset) |
| opc | input | 3 | Low instruction-code bits |
| bitop | input | 1 | Request belongs to a bit set or clear instruction |
| dbank | input | 3 | Direct bank pointer |
| idx | input | 16 | Index register |
| xptr | input | 16 | Extra pointer register |
| rbank | input | 5 | Register bank pointer |
| rd_stb | input | 1 | Read-back byte strobe |
| rd_data | input | 8 | Byte read back from memory |
| set_bit | input | 1 | 1 forces the bit high, 0 forces it low |
| addr | output | 16 | Generated address |
| bit_idx | output | 3 | Bit position within the byte |
| addr_vld | output | 1 | Address valid pulse |
| illegal | output | 1 | Bit operation requested in a mode without a bit field |
| wr_data | output | 8 | Merged byte for write-back |
| wr_vld | output | 1 | Write-back byte valid pulse |

## Verification
The wrap of the index sum past 0xFFFF, and below 0x0000 with a negative offset, is reached only by pairing an index near one end with an offset of the right sign. Random index values seldom do this, so directed cases place the index at 0x0000 and 0xFFFF. The merge is checked when the targeted bit already holds the forced value and when it does not. Random read bytes and every bit position cover both cases, and back-to-back requests check that the valid pulse stays high across consecutive strobes.

// File: rtl/opnd_addr_gen.sv
module opnd_addr_gen (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic [1:0]  mode,
  input  logic [7:0]  opnd,
  input  logic [2:0]  opc,
  input  logic        bitop,
  input  logic [2:0]  dbank,
  input  logic [15:0] idx,
  input  logic [15:0] xptr,
  input  logic [4:0]  rbank,
  input  logic        rd_stb,
  input  logic [7:0]  rd_data,
  input  logic        set_bit,
  output logic [15:0] addr,
  output logic [2:0]  bit_idx,
  output logic        addr_vld,
  output logic        illegal,
  output logic [7:0]  wr_data,
  output logic        wr_vld
);

  localparam logic [1:0] M_DIR = 2'd0, M_IDX = 2'd1, M_PTR = 2'd2, M_REG = 2'd3;

  logic [15:0] dir_a, idx_a, reg_a, nxt_a;
  logic [7:0]  mask;

  assign dir_a = opnd[7] ? 16'h0080 + {6'd0, dbank, opnd[6:0]} : {8'h00, opnd};
  assign idx_a = idx + {{8{opnd[7]}}, opnd};
  assign reg_a = {8'h01, rbank, opc};
  assign mask  = 8'h01 << bit_idx;

  always_comb begin
    case (mode)
      M_DIR:   nxt_a = dir_a;
      M_IDX:   nxt_a = idx_a;
      M_PTR:   nxt_a = xptr;
      default: nxt_a = reg_a;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0; bit_idx <= '0; addr_vld <= 1'b0; illegal <= 1'b0;
      wr_data <= '0; wr_vld <= 1'b0;
    end else begin
      addr_vld <= req;
      illegal  <= req && bitop && (mode != M_DIR);
      if (req) begin
        addr    <= nxt_a;
        bit_idx <= (mode == M_DIR) ? opc : 3'd0;
      end
      wr_vld <= rd_stb;
      if (rd_stb) wr_data <= set_bit ? (rd_data | mask) : (rd_data & ~mask);
    end
  end

  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (addr_vld == $past(req)));
  a_r2_window: assert property (@(posedge clk) disable iff (rst)
    (req && mode == M_DIR && opnd[7]) |=> (addr >= 16'h0080 && addr <= 16'h047F));
  a_r5_pointer: assert property (@(posedge clk) disable iff (rst)
    (req && mode == M_PTR) |=> (addr == $past(xptr)));
  a_r3_bit_zero: assert property (@(posedge clk) disable iff (rst)
    (req && mode != M_DIR) |=> (bit_idx == 3'd0));
  a_r9_legal: assert property (@(posedge clk) disable iff (rst)
    !addr_vld |-> !illegal);
  a_r12_wr_pulse: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (wr_vld == $past(rd_stb)));
  a_r10_only_one_bit: assert property (@(posedge clk) disable iff (rst)
    rd_stb |=> ((($past(rd_data) ^ wr_data) & ~(8'h01 << $past(bit_idx))) == 8'h00));
  a_r8_reset: assert property (@(posedge clk)
    rst |=> (!addr_vld && !wr_vld && !illegal && addr == 16'h0000));

endmodule

// File: tb/opnd_addr_gen_test.sv
module opnd_addr_gen_test;
  logic clk = 0, rst = 1, req = 0, bitop = 0, rd_stb = 0, set_bit = 0;
  logic [1:0] mode = 0;
  logic [7:0] opnd = 0, rd_data = 0;
  logic [2:0] opc = 0, dbank = 0;
  logic [15:0] idx = 0, xptr = 0;
  logic [4:0] rbank = 0;
  logic [15:0] addr;
  logic [2:0] bit_idx;
  logic addr_vld, illegal, wr_vld;
  logic [7:0] wr_data;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  opnd_addr_gen uut (.clk(clk), .rst(rst), .req(req), .mode(mode), .opnd(opnd), .opc(opc),
    .bitop(bitop), .dbank(dbank), .idx(idx), .xptr(xptr), .rbank(rbank), .rd_stb(rd_stb),
    .rd_data(rd_data), .set_bit(set_bit), .addr(addr), .bit_idx(bit_idx), .addr_vld(addr_vld),
    .illegal(illegal), .wr_data(wr_data), .wr_vld(wr_vld));

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_addr(logic [1:0] m, logic [7:0] o, logic [2:0] c,
      logic [2:0] d, logic [15:0] ix, logic [15:0] xp, logic [4:0] rb);
    logic [15:0] a;
    case (m)
      2'd0: a = (o < 8'h80) ? {8'h00, o} : 16'h0080 + 16'(d) * 16'd128 + 16'(o - 8'h80);
      2'd1: a = ix + ((o >= 8'h80) ? (16'(o) | 16'hFF00) : 16'(o));
      2'd2: a = xp;
      default: a = 16'h0100 + 16'(rb) * 16'd8 + 16'(c);
    endcase
    return a;
  endfunction

  task automatic request(logic [1:0] m, logic [7:0] o, logic [2:0] c, logic [2:0] d,
      logic [15:0] ix, logic [15:0] xp, logic [4:0] rb, logic b, string tag);
    mode = m; opnd = o; opc = c; dbank = d; idx = ix; xptr = xp; rbank = rb; bitop = b; req = 1;
    @(negedge clk); req = 0;
    chk({tag, " addr"}, addr, model_addr(m, o, c, d, ix, xp, rb));
    chk("R3 bit_idx", 16'(bit_idx), (m == 2'd0) ? 16'(c) : 16'd0);
    chk("R7 addr_vld", 16'(addr_vld), 16'd1);
    chk("R9 illegal", 16'(illegal), 16'(b && m != 2'd0));
    @(negedge clk);
    chk("R7 addr_vld low", 16'(addr_vld), 16'd0);
    chk("R7 addr hold", addr, model_addr(m, o, c, d, ix, xp, rb));
  endtask

  task automatic merge(logic [7:0] rd, logic s, logic [2:0] bi);
    logic [7:0] e;
    e = s ? (rd | (8'h01 << bi)) : (rd & ~(8'h01 << bi));
    rd_data = rd; set_bit = s; rd_stb = 1;
    @(negedge clk); rd_stb = 0;
    chk(s ? "R10 set merge" : "R11 clear merge", 16'(wr_data), 16'(e));
    chk("R12 wr_vld", 16'(wr_vld), 16'd1);
    @(negedge clk);
    chk("R12 wr_vld low", 16'(wr_vld), 16'd0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); @(negedge clk); rst = 0;
    chk("R8 reset addr", addr, 16'h0000);
    chk("R8 reset vld", 16'({addr_vld, illegal, wr_vld}), 16'd0);
    chk("R8 reset data", 16'({bit_idx, wr_data}), 16'd0);

    request(2'd0, 8'h00, 3'd0, 3'd5, 16'h0, 16'h0, 5'd0, 1, "R1 low edge");
    request(2'd0, 8'h7F, 3'd2, 3'd7, 16'h0, 16'h0, 5'd0, 1, "R1 top of low");
    request(2'd0, 8'h80, 3'd4, 3'd0, 16'h0, 16'h0, 5'd0, 1, "R2 window bottom");
    request(2'd0, 8'hFF, 3'd7, 3'd7, 16'h0, 16'h0, 5'd0, 1, "R2 window top");
    request(2'd1, 8'h5A, 3'd1, 3'd0, 16'h27A5, 16'h0, 5'd0, 0, "R4 positive");
    request(2'd1, 8'h80, 3'd0, 3'd0, 16'h0000, 16'h0, 5'd0, 1, "R4 wrap low");
    request(2'd1, 8'h01, 3'd0, 3'd0, 16'hFFFF, 16'h0, 5'd0, 0, "R4 wrap high");
    request(2'd2, 8'h00, 3'd3, 3'd0, 16'h0, 16'h27A6, 5'd0, 1, "R5 pointer");
    request(2'd3, 8'h00, 3'd7, 3'd0, 16'h0, 16'h0, 5'd31, 0, "R6 register top");
    request(2'd3, 8'h00, 3'd0, 3'd0, 16'h0, 16'h0, 5'd0, 1, "R6 register bottom");

    request(2'd0, 8'h10, 3'd6, 3'd0, 16'h0, 16'h0, 5'd0, 1, "R1 bit target");
    merge(8'h00, 1, 3'd6);
    merge(8'hFF, 0, 3'd6);
    merge(8'h40, 1, 3'd6);
    merge(8'hBF, 0, 3'd6);

    mode = 2'd2; xptr = 16'h1111; req = 1;
    @(negedge clk); xptr = 16'h2222;
    chk("R7 back-to-back first", addr, 16'h1111);
    @(negedge clk); req = 0;
    chk("R7 back-to-back second", addr, 16'h2222);
    chk("R7 back-to-back vld", 16'(addr_vld), 16'd1);
    @(negedge clk);

    for (int i = 0; i < 400; i++) begin
      logic [1:0] m; logic [2:0] c;
      m = 2'($urandom); c = 3'($urandom);
      request(m, 8'($urandom), c, 3'($urandom), 16'($urandom), 16'($urandom),
              5'($urandom), 1'($urandom), "R1 R2 R4 R5 R6 random");
      merge(8'($urandom), 1'($urandom), (m == 2'd0) ? c : 3'd0);
    end

    mode = 2'd2; xptr = 16'hABCD; req = 1; rd_stb = 1; rst = 1;
    @(negedge clk); req = 0; rd_stb = 0;
    chk("R8 mid reset addr", addr, 16'h0000);
    chk("R8 mid reset vld", 16'({addr_vld, wr_vld, illegal}), 16'd0);
    rst = 0;
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule